// File: doc/BRIEF.md
# Cascaded Timer Trigger Start Unit

This unit holds two 16-bit up-counters on one clock. A primary timer watches its capture-0 pin and turns each rising edge there into a one-cycle trigger pulse. A secondary timer can take that pulse as its own trigger. When both timers are set to start on a trigger edge, a single edge on the pin sets both run bits, and the two counters then advance in lockstep from the same value.

The trigger reaches the secondary through one more register than it takes to reach the primary. A compensation bit on the primary delays the primary's own response by that same cycle, so both timers start on the same clock. With the bit clear, the primary starts one cycle ahead of the secondary.

Software controls each run bit and each trigger flag through single-cycle pulse inputs. All configuration and control pins are plain levels or pulses. No data stream passes through the block, so it has no valid/ready interface.

Top module: `casc_trig_start`

## Requirements
- R1: While reset is asserted and right after it is released, both counts are 0 and all run bits and trigger flags are 0.
- R2: The capture-0 pin passes through two synchronizing flops. A low-to-high change seen at the synchronized end is a trigger edge. A pin that stays high, or falls, produces no further trigger.
- R3: With `msm`=1, both modes set to start-on-trigger and `s_tsel`=3'b010, a pin that is first sampled high at clock edge k sets both run bits together at edge k+3.
- R4: With `msm`=0 and the same setup, the primary run bit sets at edge k+2 and the secondary run bit sets at edge k+3.
- R5: The secondary takes the primary's trigger pulse only when `s_tsel` is 3'b010. Any other value gives it no trigger at all.
- R6: Mode value 3'b110 means start-on-trigger. With any other mode value, a trigger sets neither that timer's run bit nor its flag.
- R7: A timer's trigger flag sets in the same cycle its trigger sets its run bit. It stays set until a clear pulse arrives. A trigger and a clear in the same cycle leave the flag set.
- R8: A counter adds 1 on every clock edge at which its run bit is 1, holds while the run bit is 0, and wraps from 16'hFFFF to 0.
- R9: A set pulse raises the run bit and a clear pulse drops it, each one edge later. A set or a trigger wins over a clear in the same cycle.
- R10: Once started together from equal values, the two counts stay identical on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both timers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap0_pin | input | 1 | Primary capture-0 pin, asynchronous |
| msm | input | 1 | Primary delays its own trigger response by one cycle |
| m_mode | input | 3 | Primary mode; 3'b110 starts on trigger |
| s_tsel | input | 3 | Secondary trigger select; 3'b010 picks the primary |
| s_mode | input | 3 | Secondary mode; 3'b110 starts on trigger |
| m_cen_set | input | 1 | Pulse: set primary run bit |
| m_cen_clr | input | 1 | Pulse: clear primary run bit |
| m_flag_clr | input | 1 | Pulse: clear primary trigger flag |
| s_cen_set | input | 1 | Pulse: set secondary run bit |
| s_cen_clr | input | 1 | Pulse: clear secondary run bit |
| s_flag_clr | input | 1 | Pulse: clear secondary trigger flag |
| m_count | output | 16 | Primary count |
| s_count | output | 16 | Secondary count |
| m_cen | output | 1 | Primary run bit |
| s_cen | output | 1 | Secondary run bit |
| m_trgif | output | 1 | Primary trigger flag |
| s_trgif | output | 1 | Secondary trigger flag |

## Verification
A pin change first sampled at edge k reaches the primary run bit at edge k+2 (or k+3 with compensation) and the secondary at k+3. A count first moves at the edge after its run bit sets. Software pulses act one edge after they are driven. The bench drives every input on the falling edge and samples on the falling edge after the edge where a result is due. It compares every output against a behavioural model on each cycle, and adds directed checks at exactly k+2 and k+3.

// File: rtl/ctts_pkg.sv
package ctts_pkg;
  typedef logic [2:0] field3_t;
  localparam field3_t MODE_EVENT = 3'b110;
  localparam field3_t TSEL_PEER  = 3'b010;
endpackage

// File: rtl/ctts_edge_sync.sv
module ctts_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= pin;
  end

  genvar g;
  generate
    for (g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  // newest synchronized level high, one older low
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ctts_timer.sv
module ctts_timer
  import ctts_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  field3_t       mode,
  input  logic          trig,
  input  logic          cen_set,
  input  logic          cen_clr,
  input  logic          flag_clr,
  output logic [CW-1:0] count,
  output logic          cen,
  output logic          trgif
);
  logic start;
  assign start = trig && (mode == MODE_EVENT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen   <= 1'b0;
      trgif <= 1'b0;
      count <= '0;
    end else begin
      if (start || cen_set) cen <= 1'b1;
      else if (cen_clr)     cen <= 1'b0;
      if (start)            trgif <= 1'b1;
      else if (flag_clr)    trgif <= 1'b0;
      if (cen)              count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/casc_trig_start.sv
module casc_trig_start
  import ctts_pkg::*;
#(
  parameter int CW        = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap0_pin,
  input  logic          msm,
  input  logic [2:0]    m_mode,
  input  logic [2:0]    s_tsel,
  input  logic [2:0]    s_mode,
  input  logic          m_cen_set,
  input  logic          m_cen_clr,
  input  logic          m_flag_clr,
  input  logic          s_cen_set,
  input  logic          s_cen_clr,
  input  logic          s_flag_clr,
  output logic [CW-1:0] m_count,
  output logic [CW-1:0] s_count,
  output logic          m_cen,
  output logic          s_cen,
  output logic          m_trgif,
  output logic          s_trgif
);
  logic cap_rise;
  logic trgo_q;     // primary trigger output, registered toward the peer
  logic self_dly;   // primary's own delayed copy for start alignment
  logic m_trig, s_trig;

  ctts_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cap0_pin), .rise(cap_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trgo_q   <= 1'b0;
      self_dly <= 1'b0;
    end else begin
      trgo_q   <= cap_rise;
      self_dly <= cap_rise;
    end
  end

  assign m_trig = msm ? self_dly : cap_rise;
  assign s_trig = (s_tsel == TSEL_PEER) && trgo_q;

  ctts_timer #(.CW(CW)) u_prim (
    .clk(clk), .rst_n(rst_n), .mode(m_mode), .trig(m_trig),
    .cen_set(m_cen_set), .cen_clr(m_cen_clr), .flag_clr(m_flag_clr),
    .count(m_count), .cen(m_cen), .trgif(m_trgif)
  );

  ctts_timer #(.CW(CW)) u_sec (
    .clk(clk), .rst_n(rst_n), .mode(s_mode), .trig(s_trig),
    .cen_set(s_cen_set), .cen_clr(s_cen_clr), .flag_clr(s_flag_clr),
    .count(s_count), .cen(s_cen), .trgif(s_trgif)
  );
endmodule

// File: rtl/ctts_checker.sv
module ctts_checker
  import ctts_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msm,
  input logic [2:0]    m_mode,
  input logic [2:0]    s_tsel,
  input logic [2:0]    s_mode,
  input logic          m_cen_set,
  input logic          m_cen_clr,
  input logic          m_flag_clr,
  input logic          s_cen_set,
  input logic          s_cen_clr,
  input logic          s_flag_clr,
  input logic [CW-1:0] m_count,
  input logic [CW-1:0] s_count,
  input logic          m_cen,
  input logic          s_cen,
  input logic          m_trgif,
  input logic          s_trgif,
  input logic          trgo_q
);
  logic cfg_ok, sw_quiet;
  assign cfg_ok   = msm && (m_mode == MODE_EVENT) && (s_mode == MODE_EVENT) && (s_tsel == TSEL_PEER);
  assign sw_quiet = !m_cen_set && !s_cen_set && !m_cen_clr && !s_cen_clr;

  always @(posedge clk)
    if (!rst_n) a_r1_reset_clear: assert (m_count == '0 && s_count == '0 && !m_cen && !s_cen && !m_trgif && !s_trgif);

  a_r3_same_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_ok) && $past(sw_quiet) && !$past(m_cen) && !$past(s_cen) && (m_cen || s_cen)) |-> (m_cen && s_cen));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n) trgo_q |=> !trgo_q);

  a_r8_m_step: assert property (@(posedge clk) disable iff (!rst_n) m_cen |=> m_count == CW'($past(m_count) + 1'b1));
  a_r8_s_step: assert property (@(posedge clk) disable iff (!rst_n) s_cen |=> s_count == CW'($past(s_count) + 1'b1));
  a_r8_m_hold: assert property (@(posedge clk) disable iff (!rst_n) !m_cen |=> $stable(m_count));
  a_r8_s_hold: assert property (@(posedge clk) disable iff (!rst_n) !s_cen |=> $stable(s_count));

  a_r7_m_flag_keep: assert property (@(posedge clk) disable iff (!rst_n) (m_trgif && !m_flag_clr) |=> m_trgif);
  a_r7_s_flag_keep: assert property (@(posedge clk) disable iff (!rst_n) (s_trgif && !s_flag_clr) |=> s_trgif);

  a_r9_m_clr: assert property (@(posedge clk) disable iff (!rst_n) (m_cen && !m_cen_set && !m_cen_clr) |=> m_cen);
  a_r9_s_clr: assert property (@(posedge clk) disable iff (!rst_n) (s_cen && !s_cen_set && !s_cen_clr) |=> s_cen);
endmodule

bind casc_trig_start ctts_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msm(msm), .m_mode(m_mode), .s_tsel(s_tsel), .s_mode(s_mode),
  .m_cen_set(m_cen_set), .m_cen_clr(m_cen_clr), .m_flag_clr(m_flag_clr),
  .s_cen_set(s_cen_set), .s_cen_clr(s_cen_clr), .s_flag_clr(s_flag_clr),
  .m_count(m_count), .s_count(s_count), .m_cen(m_cen), .s_cen(s_cen),
  .m_trgif(m_trgif), .s_trgif(s_trgif), .trgo_q(trgo_q)
);

// File: tb/tb_casc_trig_start.sv
module tb_casc_trig_start;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap0_pin = 1'b0, msm = 1'b0;
  logic [2:0] m_mode = 3'b000, s_tsel = 3'b000, s_mode = 3'b000;
  logic m_cen_set = 1'b0, m_cen_clr = 1'b0, m_flag_clr = 1'b0;
  logic s_cen_set = 1'b0, s_cen_clr = 1'b0, s_flag_clr = 1'b0;
  logic [15:0] m_count, s_count;
  logic m_cen, s_cen, m_trgif, s_trgif;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  casc_trig_start dut (.*);

  // behavioural reference model
  bit hist[$];
  bit mdl_trgo, mdl_dly, mc, sc, mf, sf;
  bit e, mt, st, ms, ss;
  int mcnt, scnt;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      hist = '{1'b0, 1'b0, 1'b0};
      mdl_trgo = 0; mdl_dly = 0; mc = 0; sc = 0; mf = 0; sf = 0; mcnt = 0; scnt = 0;
    end else begin
      e  = hist[1] && !hist[2];
      mt = msm ? mdl_dly : e;
      st = (s_tsel == 3'b010) && mdl_trgo;
      ms = mt && (m_mode == 3'b110);
      ss = st && (s_mode == 3'b110);
      if (mc) mcnt = (mcnt + 1) % 65536;
      if (sc) scnt = (scnt + 1) % 65536;
      mc = (ms || m_cen_set) ? 1'b1 : (m_cen_clr ? 1'b0 : mc);
      sc = (ss || s_cen_set) ? 1'b1 : (s_cen_clr ? 1'b0 : sc);
      mf = ms ? 1'b1 : (m_flag_clr ? 1'b0 : mf);
      sf = ss ? 1'b1 : (s_flag_clr ? 1'b0 : sf);
      mdl_trgo = e; mdl_dly = e;
      hist.push_front(cap0_pin);
      void'(hist.pop_back());
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R8 m_count", int'(m_count), mcnt);
      check("R10 s_count", int'(s_count), scnt);
      check("R9 m_cen", int'(m_cen), int'(mc));
      check("R9 s_cen", int'(s_cen), int'(sc));
      check("R7 m_trgif", int'(m_trgif), int'(mf));
      check("R7 s_trgif", int'(s_trgif), int'(sf));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    m_cen_clr = 1; s_cen_clr = 1; m_flag_clr = 1; s_flag_clr = 1;
    step();
    m_cen_clr = 0; s_cen_clr = 0; m_flag_clr = 0; s_flag_clr = 0;
  endtask

  task automatic low_then_high();
    cap0_pin = 0; step(4);
    cap0_pin = 1; // first sampled at next edge k
  endtask

  logic [15:0] keep;

  initial begin
    fork
      begin
        step(3);
        check("R1 reset count", int'(m_count) + int'(s_count), 0);
        check("R1 reset bits", int'({m_cen, s_cen, m_trgif, s_trgif}), 0);
        rst_n = 1;
        step(2);
        check("R1 after release", int'({m_cen, s_cen, m_trgif, s_trgif}), 0);

        // R3: compensated lockstep start
        msm = 1; m_mode = 3'b110; s_mode = 3'b110; s_tsel = 3'b010;
        low_then_high();
        step(3);
        check("R3 no start by k+2", int'({m_cen, s_cen}), 0);
        step();
        check("R3 both start at k+3", int'({m_cen, s_cen}), 3);
        check("R7 flags with start", int'({m_trgif, s_trgif}), 3);
        step(10);
        check("R10 lockstep", int'(m_count), int'(s_count));
        check("R8 count value", int'(m_count), 10);

        // R2: held-high pin gives no new trigger
        m_flag_clr = 1; s_flag_clr = 1; step(); m_flag_clr = 0; s_flag_clr = 0;
        check("R7 flags cleared", int'({m_trgif, s_trgif}), 0);
        step(6);
        check("R2 held high no retrigger", int'({m_trgif, s_trgif}), 0);
        cap0_pin = 0; step(6);
        check("R2 falling no trigger", int'({m_trgif, s_trgif}), 0);

        // R8/R9: clear stops counting
        m_cen_clr = 1; s_cen_clr = 1; step(); m_cen_clr = 0; s_cen_clr = 0;
        check("R9 cen cleared", int'({m_cen, s_cen}), 0);
        keep = m_count; step(3);
        check("R8 hold while stopped", int'(m_count), int'(keep));

        // R7: trigger beats simultaneous flag clear
        low_then_high();
        step(3);
        m_flag_clr = 1; s_flag_clr = 1;
        step();
        m_flag_clr = 0; s_flag_clr = 0;
        check("R7 set beats clear", int'({m_trgif, s_trgif}), 3);

        // R4: no compensation, primary one cycle early
        clear_all();
        msm = 0;
        low_then_high();
        step(3);
        check("R4 primary at k+2", int'(m_cen), 1);
        check("R4 secondary not yet", int'(s_cen), 0);
        step();
        check("R4 secondary at k+3", int'(s_cen), 1);

        // R5: other trigger select
        clear_all();
        msm = 1; s_tsel = 3'b000;
        low_then_high();
        step(6);
        check("R5 primary runs", int'(m_cen), 1);
        check("R5 secondary ignores", int'({s_cen, s_trgif}), 0);

        // R6: non-event modes
        clear_all();
        s_tsel = 3'b010; m_mode = 3'b000; s_mode = 3'b100;
        keep = s_count;
        low_then_high();
        step(6);
        check("R6 no start", int'({m_cen, s_cen, m_trgif, s_trgif}), 0);
        check("R6 count unchanged", int'(s_count), int'(keep));

        // R9: set beats clear, software start
        s_cen_set = 1; s_cen_clr = 1; step(); s_cen_set = 0; s_cen_clr = 0;
        check("R9 set beats clear", int'(s_cen), 1);
        s_cen_clr = 1; step(); s_cen_clr = 0;

        // R8: wrap
        m_cen_set = 1; step(); m_cen_set = 0;
        while (m_count != 16'hFFFF) step();
        step();
        check("R8 wrap to zero", int'(m_count), 0);
      end
      begin
        step(190000);
        check("watchdog expired", 1, 0);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule